// File: doc/BRIEF.md
# Shared Port and External Bus Pin Multiplexer

This block decides, pin by pin, what a microcontroller drives onto a bank of 32 shared output pins. The pins are organised as four 8-bit output ports. In single-chip mode every pin is a plain port bit. Its level comes from the port's data register, and its output enable comes from the port's high-impedance register. In expansion mode the external memory bus takes over part of the bank. The 20 address bits drive pins 0 to 19, the read strobe drives pin 20 and the write strobe drives pin 21. Each of three chip-enable lines takes pin 24, 25 or 26, but only when software has released it through a per-bit select register.

The port data, high-impedance and chip-enable select registers sit behind a small register read/write interface. They keep working as ordinary storage whatever the pins are doing. The bus mode input passes through a two-state mode machine. The machine has states MODE_SINGLE and MODE_EXPAND. The transition ENTER_EXPAND is taken when the mode input is 1 in MODE_SINGLE. The transition LEAVE_EXPAND is taken when the mode input is 0 in MODE_EXPAND. The pins follow the registered state, so a change of bus mode reaches the pins one clock edge after it is sampled. Address decoding, strobe timing and chip-enable generation happen elsewhere and arrive here as input levels. The strobes and chip enables are active low.

Top module: `pinmux_top`

## Requirements
- R1: After reset all data registers and the chip-enable select register hold 0, every high-impedance register holds 0xFF, the mode is single-chip, and every pin_oe_o bit is 0.
- R2: In single-chip mode, pin 8*k+b drives data bit b of port k, with output enable equal to the inverse of high-impedance bit b of port k. Bus inputs and the chip-enable select have no effect on the pins in this mode.
- R3: In expansion mode, pins 0 to 19 carry bus_addr_i bits 0 to 19 in order.
- R4: In expansion mode, pin 20 carries bus_rd_n_i and pin 21 carries bus_wr_n_i.
- R5: In expansion mode, pin 24+k carries ce_n_i[k] when select bit k is 1. When select bit k is 0, the pin behaves as the port pin of R2.
- R6: Pins 22, 23 and 27 to 31 always behave as port pins, in both modes.
- R7: The registers are reachable at these addresses: 0 to 3 for data of ports 0 to 3, 4 to 7 for high-impedance of ports 0 to 3, and 8 for chip-enable select in bits 2:0 (the upper read bits are 0). A write takes effect at the clock edge, and reads are combinational. A read returns the last value written in either mode, including for bits whose pins the bus owns.
- R8: A pin owned by a bus function has output enable 1 whatever its high-impedance bit holds.
- R9: bus_mode_i is sampled at each clock edge, and the pins reflect the new mode only after the edge that samples it.
- R10: Addresses 9 to 15 read as 0, and writes to them change no register and no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_mode_i | input | 1 | 1 selects expansion mode, 0 selects single-chip mode |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from the address |
| bus_addr_i | input | 20 | External address bus value |
| bus_rd_n_i | input | 1 | Read strobe, active low |
| bus_wr_n_i | input | 1 | Write strobe, active low |
| ce_n_i | input | 3 | Chip-enable levels, active low |
| pin_out_o | output | 32 | Pin output levels, port k at bits 8k+7:8k |
| pin_oe_o | output | 32 | Pin output enables, 1 drives the pin |

## Verification
A wrong mode state puts the address, the strobes or the port data on the wrong pins. It also flips output enables on pins 0 to 21, and both show up on the first cycle after the faulty edge. A register that lost or mangled a write shows up on that pin at once in single-chip mode. On a bus-owned pin the fault is hidden at the pins and shows only through a readback at the register interface. The bench therefore pairs every pin sweep with a full register readback. Each combination of mode and chip-enable select is checked against several data, high-impedance and bus patterns, so a misrouted single bit is caught on the same cycle it is driven.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_EXPAND = 1'b1
    } bus_mode_e;

    // upper two address bits select the register kind
    typedef enum logic [1:0] {
        KIND_DATA  = 2'd0,
        KIND_HIZ   = 2'd1,
        KIND_CESEL = 2'd2,
        KIND_NONE  = 2'd3
    } reg_kind_e;

endpackage

// File: rtl/pinmux_mode_fsm.sv
module pinmux_mode_fsm
    import pinmux_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_mode_i,
    output logic expand_o
);

    bus_mode_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_SINGLE;
        else        state_q <= state_d;
    end

    // ENTER_EXPAND / LEAVE_EXPAND
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_SINGLE: if (bus_mode_i)  state_d = MODE_EXPAND;
            MODE_EXPAND: if (!bus_mode_i) state_d = MODE_SINGLE;
            default:     state_d = MODE_SINGLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            MODE_SINGLE: expand_o = 1'b0;
            MODE_EXPAND: expand_o = 1'b1;
            default:     expand_o = 1'b0;
        endcase
    end

    // R9: mode follows the sampled input one edge later
    assert_mode_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (expand_o == $past(bus_mode_i)));

endmodule

// File: rtl/pinmux_regs.sv
module pinmux_regs
    import pinmux_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 8,
    parameter int NUM_CE    = 3,
    parameter int REG_AW    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we_i,
    input  logic [REG_AW-1:0]           addr_i,
    input  logic [PORT_W-1:0]           wdata_i,
    output logic [PORT_W-1:0]           rdata_o,
    output logic [NUM_PORTS*PORT_W-1:0] data_flat_o,
    output logic [NUM_PORTS*PORT_W-1:0] hiz_flat_o,
    output logic [NUM_CE-1:0]           ce_sel_o
);

    localparam int IDX_W = REG_AW - 2;

    logic [PORT_W-1:0] data_q [NUM_PORTS];
    logic [PORT_W-1:0] hiz_q  [NUM_PORTS];
    logic [NUM_CE-1:0] ce_sel_q;

    reg_kind_e       kind;
    logic [IDX_W-1:0] idx;
    logic            idx_ok;

    assign kind   = reg_kind_e'(addr_i[REG_AW-1 -: 2]);
    assign idx    = addr_i[IDX_W-1:0];
    assign idx_ok = (int'(idx) < NUM_PORTS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_PORTS; k++) begin
                data_q[k] <= '0;
                hiz_q[k]  <= '1;
            end
            ce_sel_q <= '0;
        end else if (we_i) begin
            case (kind)
                KIND_DATA:  if (idx_ok) data_q[idx] <= wdata_i;
                KIND_HIZ:   if (idx_ok) hiz_q[idx]  <= wdata_i;
                KIND_CESEL: if (idx == '0) ce_sel_q <= wdata_i[NUM_CE-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (kind)
            KIND_DATA:  if (idx_ok) rdata_o = data_q[idx];
            KIND_HIZ:   if (idx_ok) rdata_o = hiz_q[idx];
            KIND_CESEL: if (idx == '0) rdata_o = {{(PORT_W-NUM_CE){1'b0}}, ce_sel_q};
            default:    rdata_o = '0;
        endcase
    end

    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_flat
        assign data_flat_o[k*PORT_W +: PORT_W] = data_q[k];
        assign hiz_flat_o[k*PORT_W +: PORT_W]  = hiz_q[k];
    end
    assign ce_sel_o = ce_sel_q;

    // R7: select register takes the written value
    assert_cesel_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && kind == KIND_CESEL && idx == '0) |=> (ce_sel_o == $past(wdata_i[NUM_CE-1:0])));

    // R10: writes to unmapped space leave storage alone
    assert_unmapped_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && kind == KIND_NONE) |=> ($stable(ce_sel_o) && $stable(data_flat_o) && $stable(hiz_flat_o)));

endmodule

// File: rtl/pinmux_pin_sel.sv
module pinmux_pin_sel #(
    parameter int PIN_N   = 32,
    parameter int ADDR_W  = 20,
    parameter int NUM_CE  = 3,
    parameter int CE_BASE = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expand_i,
    input  logic [NUM_CE-1:0] ce_sel_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_rd_n_i,
    input  logic              bus_wr_n_i,
    input  logic [NUM_CE-1:0] ce_n_i,
    input  logic [PIN_N-1:0]  data_i,
    input  logic [PIN_N-1:0]  hiz_i,
    output logic [PIN_N-1:0]  pin_out_o,
    output logic [PIN_N-1:0]  pin_oe_o
);

    localparam int RD_PIN = ADDR_W;
    localparam int WR_PIN = ADDR_W + 1;

    logic [PIN_N-1:0] own;
    logic [PIN_N-1:0] busv;

    for (genvar p = 0; p < PIN_N; p++) begin : g_pin
        if (p < ADDR_W) begin : g_addr
            assign own[p]  = expand_i;
            assign busv[p] = bus_addr_i[p];
        end else if (p == RD_PIN) begin : g_rd
            assign own[p]  = expand_i;
            assign busv[p] = bus_rd_n_i;
        end else if (p == WR_PIN) begin : g_wr
            assign own[p]  = expand_i;
            assign busv[p] = bus_wr_n_i;
        end else if (p >= CE_BASE && p < CE_BASE + NUM_CE) begin : g_ce
            assign own[p]  = expand_i & ce_sel_i[p-CE_BASE];
            assign busv[p] = ce_n_i[p-CE_BASE];
        end else begin : g_port
            assign own[p]  = 1'b0;
            assign busv[p] = 1'b0;
        end
        assign pin_out_o[p] = own[p] ? busv[p] : data_i[p];
        assign pin_oe_o[p]  = own[p] | ~hiz_i[p];
    end

    // R8: bus-owned address and strobe pins are always driven
    assert_owned_driven_R8: assert property (@(posedge clk) disable iff (!rst_n)
        expand_i |-> (&pin_oe_o[WR_PIN:0]));

endmodule

// File: rtl/pinmux_top.sv
module pinmux_top
    import pinmux_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 8,
    parameter int ADDR_W    = 20,
    parameter int NUM_CE    = 3,
    parameter int CE_PORT   = 3,
    parameter int REG_AW    = $clog2(NUM_PORTS) + 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_mode_i,
    input  logic                        reg_we_i,
    input  logic [REG_AW-1:0]           reg_addr_i,
    input  logic [PORT_W-1:0]           reg_wdata_i,
    output logic [PORT_W-1:0]           reg_rdata_o,
    input  logic [ADDR_W-1:0]           bus_addr_i,
    input  logic                        bus_rd_n_i,
    input  logic                        bus_wr_n_i,
    input  logic [NUM_CE-1:0]           ce_n_i,
    output logic [NUM_PORTS*PORT_W-1:0] pin_out_o,
    output logic [NUM_PORTS*PORT_W-1:0] pin_oe_o
);

    localparam int PIN_N   = NUM_PORTS * PORT_W;
    localparam int CE_BASE = CE_PORT * PORT_W;

    logic              expand;
    logic [PIN_N-1:0]  data_flat;
    logic [PIN_N-1:0]  hiz_flat;
    logic [NUM_CE-1:0] ce_sel;

    pinmux_mode_fsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_mode_i (bus_mode_i),
        .expand_o   (expand)
    );

    pinmux_regs #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W),
        .NUM_CE    (NUM_CE),
        .REG_AW    (REG_AW)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (reg_we_i),
        .addr_i      (reg_addr_i),
        .wdata_i     (reg_wdata_i),
        .rdata_o     (reg_rdata_o),
        .data_flat_o (data_flat),
        .hiz_flat_o  (hiz_flat),
        .ce_sel_o    (ce_sel)
    );

    pinmux_pin_sel #(
        .PIN_N   (PIN_N),
        .ADDR_W  (ADDR_W),
        .NUM_CE  (NUM_CE),
        .CE_BASE (CE_BASE)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .expand_i   (expand),
        .ce_sel_i   (ce_sel),
        .bus_addr_i (bus_addr_i),
        .bus_rd_n_i (bus_rd_n_i),
        .bus_wr_n_i (bus_wr_n_i),
        .ce_n_i     (ce_n_i),
        .data_i     (data_flat),
        .hiz_i      (hiz_flat),
        .pin_out_o  (pin_out_o),
        .pin_oe_o   (pin_oe_o)
    );

    // R2: single-chip pins mirror the port registers
    assert_single_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !expand |-> (pin_out_o == data_flat && pin_oe_o == ~hiz_flat));

    // R3: address bus on the low pins
    assert_addr_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
        expand |-> (pin_out_o[ADDR_W-1:0] == bus_addr_i));

    // R4: strobes directly above the address
    assert_strobe_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expand |-> (pin_out_o[ADDR_W] == bus_rd_n_i && pin_out_o[ADDR_W+1] == bus_wr_n_i));

    // R5: released chip enables carry their levels
    assert_ce_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expand |-> (((pin_out_o[CE_BASE +: NUM_CE] ^ ce_n_i) & ce_sel) == '0));

endmodule

// File: tb/pinmux_top_test.sv
module pinmux_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_mode_i = 1'b0;
    logic        reg_we_i = 1'b0;
    logic [3:0]  reg_addr_i = '0;
    logic [7:0]  reg_wdata_i = '0;
    logic [7:0]  reg_rdata_o;
    logic [19:0] bus_addr_i = '0;
    logic        bus_rd_n_i = 1'b1;
    logic        bus_wr_n_i = 1'b1;
    logic [2:0]  ce_n_i = '1;
    logic [31:0] pin_out_o;
    logic [31:0] pin_oe_o;

    int checks = 0;
    int failures = 0;

    logic [7:0] sh_data [4];
    logic [7:0] sh_hiz  [4];
    logic [2:0] sh_cesel;
    logic       sh_mode;

    always #10 clk = ~clk;

    pinmux_top uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_mode_i  (bus_mode_i),
        .reg_we_i    (reg_we_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .bus_addr_i  (bus_addr_i),
        .bus_rd_n_i  (bus_rd_n_i),
        .bus_wr_n_i  (bus_wr_n_i),
        .ce_n_i      (ce_n_i),
        .pin_out_o   (pin_out_o),
        .pin_oe_o    (pin_oe_o)
    );

    function automatic string req_of(int p, logic m);
        if (!m) return "R2";
        if (p < 20) return "R3";
        if (p < 22) return "R4";
        if (p >= 24 && p < 27) return "R5";
        return "R6";
    endfunction

    task automatic check_pins(string tag);
        logic [31:0] eo, ee;
        for (int p = 0; p < 32; p++) begin
            logic owned, bv;
            owned = 1'b0;
            bv = 1'b0;
            if (sh_mode) begin
                if (p < 20) begin owned = 1'b1; bv = bus_addr_i[p]; end
                else if (p == 20) begin owned = 1'b1; bv = bus_rd_n_i; end
                else if (p == 21) begin owned = 1'b1; bv = bus_wr_n_i; end
                else if (p >= 24 && p < 27 && sh_cesel[p-24]) begin
                    owned = 1'b1; bv = ce_n_i[p-24];
                end
            end
            eo[p] = owned ? bv : sh_data[p/8][p%8];
            ee[p] = owned | ~sh_hiz[p/8][p%8];
        end
        checks++;
        if (pin_out_o !== eo) begin
            int bad = 0;
            failures++;
            for (int p = 31; p >= 0; p--) if (pin_out_o[p] !== eo[p]) bad = p;
            $display("FAIL %s %s pin_out actual=%h expected=%h", req_of(bad, sh_mode), tag, pin_out_o, eo);
        end
        checks++;
        if (pin_oe_o !== ee) begin
            int bad = 0;
            failures++;
            for (int p = 31; p >= 0; p--) if (pin_oe_o[p] !== ee[p]) bad = p;
            $display("FAIL %s/R8 %s pin_oe actual=%h expected=%h", req_of(bad, sh_mode), tag, pin_oe_o, ee);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(posedge clk);
        #1 reg_we_i = 1'b0;
        if (a < 4) sh_data[a] = d;
        else if (a < 8) sh_hiz[a-4] = d;
        else if (a == 8) sh_cesel = d[2:0];
    endtask

    task automatic rd_check(input logic [3:0] a, string tag);
        logic [7:0] exp_v;
        @(negedge clk);
        reg_addr_i = a;
        #2;
        if (a < 4) exp_v = sh_data[a];
        else if (a < 8) exp_v = sh_hiz[a-4];
        else if (a == 8) exp_v = {5'b0, sh_cesel};
        else exp_v = 8'h00;
        checks++;
        if (reg_rdata_o !== exp_v) begin
            failures++;
            $display("FAIL %s read addr=%0d actual=%h expected=%h", tag, a, reg_rdata_o, exp_v);
        end
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        bus_mode_i = m;
        @(posedge clk);
        #1 sh_mode = m;
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) begin sh_data[k] = 8'h00; sh_hiz[k] = 8'hFF; end
        sh_cesel = 3'b000;
        sh_mode = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state at pins and registers
        @(negedge clk);
        check_pins("R1 reset");
        for (int a = 0; a < 9; a++) rd_check(4'(a), "R1 reset");

        // R2..R8 sweep over mode, select and patterns
        for (int m = 0; m < 2; m++) begin
            set_mode(1'(m));
            for (int cs = 0; cs < 8; cs++) begin
                wr(4'd8, 8'(cs) | 8'hF8);
                for (int pat = 0; pat < 4; pat++) begin
                    for (int k = 0; k < 4; k++) begin
                        wr(4'(k), 8'((pat * 8'h3B) ^ (k * 8'h51) ^ 8'hA5));
                        wr(4'(4 + k), 8'((pat * 8'h6D) ^ (k * 8'h27) ^ cs));
                    end
                    @(negedge clk);
                    bus_addr_i = 20'((pat * 20'h5A3C7) ^ (cs * 20'h1F0E1) ^ (m * 20'hFFFFF));
                    bus_rd_n_i = pat[0];
                    bus_wr_n_i = pat[1] ^ cs[0];
                    ce_n_i     = 3'(pat ^ cs ^ m);
                    #2 check_pins(m ? "R3 R4 R5 R6 R8 sweep" : "R2 R6 sweep");
                end
                // R7: storage reads back while bus owns pins
                for (int a = 0; a < 9; a++) rd_check(4'(a), "R7 readback");
            end
        end

        // R10: unmapped space
        for (int a = 9; a < 16; a++) begin
            wr(4'(a), 8'hFF);
            rd_check(4'(a), "R10 unmapped read");
        end
        for (int a = 0; a < 9; a++) rd_check(4'(a), "R10 no side effect");
        @(negedge clk);
        check_pins("R10 pins unchanged");

        // R9: mode change latency, expand -> single
        @(negedge clk);
        bus_mode_i = 1'b0;
        #5 check_pins("R9 before edge");
        @(posedge clk);
        #1 sh_mode = 1'b0;
        @(negedge clk);
        check_pins("R9 after edge to single");
        // single -> expand
        @(negedge clk);
        bus_mode_i = 1'b1;
        #5 check_pins("R9 before edge");
        @(posedge clk);
        #1 sh_mode = 1'b1;
        @(negedge clk);
        check_pins("R9 after edge to expand");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule